// File: doc/BRIEF.md
# 8-bit CPU Next-Address Generator

This block forms the 16-bit memory address driven in every microcycle of an 8-bit accumulator processor, and it owns the program counter. A 4-bit address opcode from the microword picks the address source: the incremented PC, the memory address register (MAR) with or without an increment, a page-one stack slot, a page-zero base with optional X or Y indexing, or a full 16-bit operand with optional indexing. A zero-page control bit forces the high byte of the result to zero. The microcode sets that bit for each addressing mode that must wrap within page zero and clears it for the final Y addition of the indirect-indexed mode, which may cross a page.

The selected address reaches the address bus combinationally and is captured into the MAR. A 2-bit PC opcode holds, increments, jumps or conditionally branches the PC. A delayed PC copy keeps the PC value from before the last update. The stacking logic uses that copy when an interrupt is taken, while subroutine calls stack the live PC. All state advances only on cycles where the ready strobe is high.

There is no control sequence here: the block is a datapath steered each cycle by the two opcodes. It has no named states or transitions.

Top module: `cpu_addr_gen`

## Requirements
- R1: `na_op` selects the address source: 1 gives PC+1, 2 gives MAR, 3 gives MAR+1, 4 gives stack, 5 gives {0x00,op1}, 6 gives {0x00,op1}+X, 7 gives {0x00,op1}+Y, 8 gives {op2,op1}, 0xE gives {op2,op1}+X, 0xF gives {op2,op1}+Y. All sums are 16-bit, so without wrap a page-zero index may carry into page one.
- R2: While `zp_wrap` is 1, `addr[15:8]` is 0x00 and `addr[7:0]` is the low byte of the selected sum, for every source. This covers indexed page-zero sums and the MAR+1 step that fetches a pointer's high byte.
- R3: `na_op` codes 0 and 9 to 0xD select the MAR unchanged.
- R4: The stack address is {0x01, stk_ptr} when `stk_pop` is 0, and {0x01, stk_ptr+1 mod 256} when `stk_pop` is 1.
- R5: `pc_op` has four codes. 0 holds the PC. 1 increments it. 2 loads {di, op1}.
- R6: `pc_op` 3 loads PC+1 plus the sign-extended `di` when `cc` is 1, and PC+1 otherwise.
- R7: A synchronous reset clears the MAR and loads both the PC and the delayed PC from `vector`.
- R8: The MAR, the PC and the delayed PC change only on a rising edge where `rdy` is 1. `addr` follows its inputs combinationally.
- R9: On each rising edge where `rdy` is 1, `pc_dly` takes the PC value held before that edge.
- R10: When `dec_step` and `int_req` are both 1 on a ready edge, the PC loads `vector` regardless of `pc_op`. If either of the two is 0, `pc_op` governs the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdy | input | 1 | Ready strobe; enables state updates |
| na_op | input | 4 | Next-address opcode |
| zp_wrap | input | 1 | Force result into page zero |
| stk_pop | input | 1 | Stack access is a pop (pointer + 1) |
| pc_op | input | 2 | Program-counter opcode |
| cc | input | 1 | Branch condition true |
| dec_step | input | 1 | Microword is a conditional decode step |
| int_req | input | 1 | Interrupt pending |
| vector | input | 16 | Reset / interrupt target address |
| di | input | 8 | Data input byte (jump high byte, branch offset) |
| op1 | input | 8 | Operand byte 1 (low) |
| op2 | input | 8 | Operand byte 2 (high) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| stk_ptr | input | 8 | Stack pointer |
| addr | output | 16 | Memory address bus |
| pc | output | 16 | Program counter |
| pc_dly | output | 16 | PC before the last ready update |

## Verification
The hardest cases to reach are those that depend on the MAR already holding a page-boundary value. The clearest is the pointer high-byte fetch, where MAR+1 from 0x00FF must give 0x0000 with wrap and 0x0100 without it.

The bench first loads the MAR on a ready edge through the page-zero source with operand 0xFF. It then applies the MAR+1 opcode with the wrap bit in both states, without a clock edge.

A second case holds `rdy` low while both opcodes request changes, to show that nothing moves. A third chains PC updates so that every `pc_dly` value is a known earlier PC.

// File: rtl/cpu_addr_gen_pkg.sv
package cpu_addr_gen_pkg;

    typedef enum logic [3:0] {
        NA_PC_INC  = 4'h1,
        NA_MAR     = 4'h2,
        NA_MAR_INC = 4'h3,
        NA_STACK   = 4'h4,
        NA_ZP      = 4'h5,
        NA_ZP_X    = 4'h6,
        NA_ZP_Y    = 4'h7,
        NA_ABS     = 4'h8,
        NA_ABS_X   = 4'hE,
        NA_ABS_Y   = 4'hF
    } na_op_e;

    typedef enum logic [1:0] {
        PC_HOLD   = 2'd0,
        PC_INC    = 2'd1,
        PC_JUMP   = 2'd2,
        PC_BRANCH = 2'd3
    } pc_op_e;

    localparam logic [7:0] STACK_PAGE = 8'h01;

endpackage

// File: rtl/cpu_addr_sel.sv
module cpu_addr_sel
    import cpu_addr_gen_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
)(
    input  logic [3:0]    na_op,
    input  logic          zp_wrap,
    input  logic          stk_pop,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] mar,
    input  logic [DW-1:0] op1,
    input  logic [DW-1:0] op2,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [DW-1:0] stk_ptr,
    output logic [AW-1:0] addr
);
    localparam int HW = AW - DW;

    logic [AW-1:0] zp_base;
    logic [AW-1:0] abs_base;
    logic [AW-1:0] x_wide;
    logic [AW-1:0] y_wide;
    logic [DW-1:0] stk_slot;
    logic [AW-1:0] sum;

    assign zp_base  = {{HW{1'b0}}, op1};
    assign abs_base = {op2[HW-1:0], op1};
    assign x_wide   = {{HW{1'b0}}, idx_x};
    assign y_wide   = {{HW{1'b0}}, idx_y};
    assign stk_slot = stk_ptr + {{(DW-1){1'b0}}, stk_pop};

    always_comb begin
        unique case (na_op_e'(na_op))
            NA_PC_INC:  sum = pc + AW'(1);
            NA_MAR:     sum = mar;
            NA_MAR_INC: sum = mar + AW'(1);
            NA_STACK:   sum = {HW'(STACK_PAGE), stk_slot};
            NA_ZP:      sum = zp_base;
            NA_ZP_X:    sum = zp_base + x_wide;
            NA_ZP_Y:    sum = zp_base + y_wide;
            NA_ABS:     sum = abs_base;
            NA_ABS_X:   sum = abs_base + x_wide;
            NA_ABS_Y:   sum = abs_base + y_wide;
            default:    sum = mar;
        endcase
    end

    assign addr = zp_wrap ? {{HW{1'b0}}, sum[DW-1:0]} : sum;

    always_comb begin
        if (!zp_wrap && na_op == 4'h4)
            AST_STACK_PAGE: assert (addr[AW-1:DW] == HW'(STACK_PAGE)); // R4
    end

endmodule

// File: rtl/cpu_pc_unit.sv
module cpu_pc_unit
    import cpu_addr_gen_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          rdy,
    input  logic [1:0]    pc_op,
    input  logic          cc,
    input  logic          dec_step,
    input  logic          int_req,
    input  logic [AW-1:0] vector,
    input  logic [DW-1:0] di,
    input  logic [DW-1:0] op1,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pc_dly
);
    localparam int HW = AW - DW;

    logic [AW-1:0] pc_q, dly_q, pc_nxt, pc_plus, rel_off;
    logic          take_vec;

    assign pc_plus  = pc_q + AW'(1);
    assign rel_off  = {{HW{di[DW-1]}}, di};
    assign take_vec = dec_step && int_req;

    always_comb begin
        if (take_vec) begin
            pc_nxt = vector;
        end else begin
            unique case (pc_op_e'(pc_op))
                PC_HOLD:   pc_nxt = pc_q;
                PC_INC:    pc_nxt = pc_plus;
                PC_JUMP:   pc_nxt = {di[HW-1:0], op1};
                PC_BRANCH: pc_nxt = cc ? (pc_plus + rel_off) : pc_plus;
                default:   pc_nxt = pc_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= vector;
            dly_q <= vector;
        end else if (rdy) begin
            pc_q  <= pc_nxt;
            dly_q <= pc_q;
        end
    end

    assign pc     = pc_q;
    assign pc_dly = dly_q;

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(pc)); // R8
    AST_DLY_TRACK: assert property (@(posedge clk) disable iff (rst)
        rdy |=> pc_dly == $past(pc)); // R9
    AST_PC_INC: assert property (@(posedge clk) disable iff (rst)
        rdy && !take_vec && pc_op == 2'd1 |=> pc == $past(pc) + AW'(1)); // R5
    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
        rdy && dec_step && int_req |=> pc == $past(vector)); // R10

endmodule

// File: rtl/cpu_addr_gen.sv
module cpu_addr_gen
    import cpu_addr_gen_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          rdy,
    input  logic [3:0]    na_op,
    input  logic          zp_wrap,
    input  logic          stk_pop,
    input  logic [1:0]    pc_op,
    input  logic          cc,
    input  logic          dec_step,
    input  logic          int_req,
    input  logic [AW-1:0] vector,
    input  logic [DW-1:0] di,
    input  logic [DW-1:0] op1,
    input  logic [DW-1:0] op2,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [DW-1:0] stk_ptr,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pc_dly
);
    logic [AW-1:0] mar_q;
    logic [AW-1:0] addr_w;

    cpu_pc_unit #(.AW(AW), .DW(DW)) u_pc (
        .clk(clk), .rst(rst), .rdy(rdy), .pc_op(pc_op), .cc(cc),
        .dec_step(dec_step), .int_req(int_req), .vector(vector),
        .di(di), .op1(op1), .pc(pc), .pc_dly(pc_dly)
    );

    cpu_addr_sel #(.AW(AW), .DW(DW)) u_sel (
        .na_op(na_op), .zp_wrap(zp_wrap), .stk_pop(stk_pop), .pc(pc),
        .mar(mar_q), .op1(op1), .op2(op2), .idx_x(idx_x), .idx_y(idx_y),
        .stk_ptr(stk_ptr), .addr(addr_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mar_q <= '0;
        else if (rdy)
            mar_q <= addr_w;
    end

    assign addr = addr_w;

    AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(mar_q)); // R8
    AST_MAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        rdy |=> mar_q == $past(addr)); // R8
    AST_ZP_PAGE: assert property (@(posedge clk) disable iff (rst)
        zp_wrap |-> addr[AW-1:DW] == '0); // R2

endmodule

// File: tb/cpu_addr_gen_bench.sv
module cpu_addr_gen_bench;
    localparam int PER = 10;

    logic        clk = 0, rst = 1, rdy = 0;
    logic [3:0]  na_op = 0;
    logic        zp_wrap = 0, stk_pop = 0, cc = 0, dec_step = 0, int_req = 0;
    logic [1:0]  pc_op = 0;
    logic [15:0] vector = 16'h1234;
    logic [7:0]  di = 0, op1 = 0, op2 = 0, idx_x = 0, idx_y = 0, stk_ptr = 0;
    logic [15:0] addr, pc, pc_dly;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(PER/2) clk = ~clk;

    cpu_addr_gen u_cpu_addr_gen (
        .clk(clk), .rst(rst), .rdy(rdy), .na_op(na_op), .zp_wrap(zp_wrap),
        .stk_pop(stk_pop), .pc_op(pc_op), .cc(cc), .dec_step(dec_step),
        .int_req(int_req), .vector(vector), .di(di), .op1(op1), .op2(op2),
        .idx_x(idx_x), .idx_y(idx_y), .stk_ptr(stk_ptr),
        .addr(addr), .pc(pc), .pc_dly(pc_dly)
    );

    typedef struct packed {
        logic [3:0]  na;
        logic        zp;
        logic        pop;
        logic [7:0]  o1, o2, x, y, sp;
        logic [15:0] exp;
    } vec_t;

    // State during the table: MAR = 0x0000, PC = 0x1234, rdy low
    localparam vec_t TBL [16] = '{
        '{4'h1, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h1235}, // R1
        '{4'h2, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0000}, // R1
        '{4'h3, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0001}, // R1
        '{4'h4, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h01FF}, // R4
        '{4'h4, 1'b0, 1'b1, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0100}, // R4
        '{4'h5, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h00F0}, // R1
        '{4'h6, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0110}, // R1
        '{4'h6, 1'b1, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0010}, // R2
        '{4'h7, 1'b1, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h00F5}, // R2
        '{4'h8, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h12F0}, // R1
        '{4'hE, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h1310}, // R1
        '{4'hF, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h12F5}, // R1
        '{4'hE, 1'b1, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0010}, // R2
        '{4'h9, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0000}, // R3
        '{4'h0, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0000}, // R3
        '{4'h1, 1'b1, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h05, 8'hFF, 16'h0035}  // R2
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(PER/4);
    endtask

    initial begin
        #(PER*5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset: R7
        tick(); tick();
        rst = 0; na_op = 4'h2;
        #1;
        chk("R7 pc", pc, 16'h1234);
        chk("R7 pc_dly", pc_dly, 16'h1234);
        chk("R7 mar", addr, 16'h0000);

        for (int i = 0; i < 16; i++) begin
            na_op = TBL[i].na; zp_wrap = TBL[i].zp; stk_pop = TBL[i].pop;
            op1 = TBL[i].o1; op2 = TBL[i].o2; idx_x = TBL[i].x;
            idx_y = TBL[i].y; stk_ptr = TBL[i].sp;
            #1;
            chk($sformatf("R1/R2/R3/R4 table %0d", i), addr, TBL[i].exp);
        end
        zp_wrap = 0; stk_pop = 0;

        // R8: MAR load on ready
        rdy = 1; na_op = 4'h8; op2 = 8'hAB; op1 = 8'hCD; pc_op = 2'd0;
        tick();
        na_op = 4'h2; #1;
        chk("R8 mar load", addr, 16'hABCD);
        chk("R5 hold", pc, 16'h1234);

        // R8: nothing moves with rdy low
        rdy = 0; na_op = 4'h5; op1 = 8'h11; pc_op = 2'd1;
        tick();
        na_op = 4'h2; #1;
        chk("R8 mar stable", addr, 16'hABCD);
        chk("R8 pc stable", pc, 16'h1234);

        // MAR = 0x00FF, PC increment
        rdy = 1; na_op = 4'h5; op1 = 8'hFF; pc_op = 2'd1;
        tick();
        rdy = 0;
        chk("R5 inc", pc, 16'h1235);
        chk("R9 dly", pc_dly, 16'h1234);
        na_op = 4'h3; zp_wrap = 1; #1;
        chk("R2 ptr high wrap", addr, 16'h0000);
        zp_wrap = 0; #1;
        chk("R1 mar+1 carry", addr, 16'h0100);

        // Jump: R5
        rdy = 1; na_op = 4'h2; pc_op = 2'd2; di = 8'h80; op1 = 8'h00;
        tick();
        chk("R5 jump", pc, 16'h8000);
        chk("R9 dly jump", pc_dly, 16'h1235);

        // Branches: R6
        pc_op = 2'd3; cc = 1; di = 8'hFE;
        tick();
        chk("R6 taken back", pc, 16'h7FFF);
        cc = 0; di = 8'h10;
        tick();
        chk("R6 not taken", pc, 16'h8000);
        cc = 1; di = 8'h10;
        tick();
        chk("R6 taken fwd", pc, 16'h8011);

        // Interrupt vector: R10
        pc_op = 2'd1; cc = 0; dec_step = 1; int_req = 1; vector = 16'hFFE0;
        tick();
        chk("R10 vector", pc, 16'hFFE0);
        chk("R9 dly int", pc_dly, 16'h8011);
        int_req = 0;
        tick();
        chk("R10 no int", pc, 16'hFFE1);
        dec_step = 0; int_req = 1;
        tick();
        chk("R10 not decode", pc, 16'hFFE2);
        int_req = 0; pc_op = 2'd0;
        tick();
        chk("R5 hold2", pc, 16'hFFE2);
        chk("R9 dly hold", pc_dly, 16'hFFE2);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule